// File: doc/BRIEF.md
# Nonvolatile Store/Recall Control Sequencer

This block sequences a shadowed SRAM that has a nonvolatile copy behind every cell. It samples four active-low controls: chip select, output enable, write enable and nonvolatile select. It also takes a flag that is high while the supply is above its switch threshold. From these it decides whether the array is in plain SRAM mode, copying SRAM into the nonvolatile cells (STORE), or copying the nonvolatile cells back into SRAM (RECALL). It reports that decision as one-cycle start strobes, a busy flag, and read and write gates for the SRAM array. The read gate also enables the data-bus drivers, so the bus floats whenever the block is busy.

A nonvolatile cycle starts only on a transition into its command state. A command level that is simply held, such as one still present when a cycle ends or one already present when reset is released, does nothing. Cycle lengths are parameters counted in clocks. A rising supply flag launches a RECALL that lasts for the restore window. The block has no data path, so none of its pins carries a valid/ready stream. All pins are plain level or strobe signals.

Top module: `nvs_ctrl`

## Requirements
- R1: When the block is idle and supply_ok is high, a clock edge that sees the STORE state (nv_n=0, ce_n=0, we_n=0, oe_n=1) after an edge that did not see it pulses store_go for one cycle after that edge. busy then stays high for exactly STORE_CLKS cycles.
- R2: When idle, a clock edge that first sees the RECALL state (nv_n=0, ce_n=0, oe_n=0, we_n=1) pulses recall_go for one cycle after that edge. busy then stays high for exactly RECALL_CLKS cycles.
- R3: A command state that is held does not start a cycle. This covers a state still present when a cycle ends and a state present at the first edge after reset release.
- R4: While busy is high, sram_rd and sram_wr are low and every control input is ignored. A command edge seen during a cycle never starts a later cycle.
- R5: At an idle edge where supply_ok is low, a STORE command edge starts nothing.
- R6: If supply_ok is sampled low during a STORE, busy falls after that edge.
- R7: A clock edge where supply_ok is high and was low at the previous edge, including the first edge after reset, starts a RECALL. That RECALL pulses recall_go and keeps busy high for RESTORE_CLKS cycles. It overrides any external command seen at the same edge, and that command is discarded.
- R8: sram_rd = !busy & !ce_n & !oe_n & we_n & nv_n and sram_wr = !busy & !ce_n & !we_n & nv_n, both combinational. A read state present when busy falls takes effect in that same cycle.
- R9: During reset, busy, store_go and recall_go are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Nonvolatile select, active low |
| supply_ok | input | 1 | Supply above switch threshold |
| store_go | output | 1 | One-cycle strobe: STORE begun |
| recall_go | output | 1 | One-cycle strobe: RECALL begun |
| busy | output | 1 | Nonvolatile cycle in progress |
| sram_rd | output | 1 | SRAM read gate and data-bus drive enable |
| sram_wr | output | 1 | SRAM write gate |

## Verification
Two functions can fall in the same cycle: the power-up RECALL and an external command edge. The bench raises supply_ok at the same falling clock edge that moves the controls into the STORE state. It expects recall_go, never store_go, and no STORE after the restore window while the command is still held. The other same-cycle case is the end of a cycle meeting a waiting read or a held command. It is judged by whether sram_rd rises in the same cycle as busy falls and whether no second strobe appears.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    NV_IDLE   = 2'd0,
    NV_STORE  = 2'd1,
    NV_RECALL = 2'd2
  } nv_mode_t;
endpackage

// File: rtl/nvs_cmd_decode.sv
module nvs_cmd_decode (
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic nv_n,
  input  logic busy,
  output logic is_store,
  output logic is_recall,
  output logic sram_rd,
  output logic sram_wr
);
  // Nonvolatile command levels
  assign is_store  = !nv_n && !ce_n && !we_n && oe_n;
  assign is_recall = !nv_n && !ce_n && !oe_n && we_n;
  // Plain SRAM access, suppressed while a nonvolatile cycle runs
  assign sram_rd = !busy && !ce_n && !oe_n && we_n && nv_n;
  assign sram_wr = !busy && !ce_n && !we_n && nv_n;
endmodule

// File: rtl/nvs_edge_arm.sv
module nvs_edge_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic is_store,
  input  logic is_recall,
  input  logic supply_ok,
  output logic store_edge,
  output logic recall_edge,
  output logic pwr_rise
);
  logic prev_store, prev_recall, supply_q, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_store  <= 1'b0;
      prev_recall <= 1'b0;
      supply_q    <= 1'b0;
      armed       <= 1'b0;
    end else begin
      prev_store  <= is_store;
      prev_recall <= is_recall;
      supply_q    <= supply_ok;
      armed       <= 1'b1;
    end
  end

  // The first edge after reset only records levels, so a held command is ignored
  assign store_edge  = armed && is_store && !prev_store;
  assign recall_edge = armed && is_recall && !prev_recall;
  assign pwr_rise    = supply_ok && !supply_q;
endmodule

// File: rtl/nvs_cycle_timer.sv
module nvs_cycle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len_m1,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= len_m1;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl #(
  parameter int STORE_CLKS   = 2000000,
  parameter int RECALL_CLKS  = 4000,
  parameter int RESTORE_CLKS = 130000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic nv_n,
  input  logic supply_ok,
  output logic store_go,
  output logic recall_go,
  output logic busy,
  output logic sram_rd,
  output logic sram_wr
);
  import nvs_pkg::*;

  localparam int MAXC_A = (STORE_CLKS > RECALL_CLKS) ? STORE_CLKS : RECALL_CLKS;
  localparam int MAXC   = (MAXC_A > RESTORE_CLKS) ? MAXC_A : RESTORE_CLKS;
  localparam int CW     = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ST_M1 = CW'(STORE_CLKS - 1);
  localparam logic [CW-1:0] RC_M1 = CW'(RECALL_CLKS - 1);
  localparam logic [CW-1:0] RS_M1 = CW'(RESTORE_CLKS - 1);

  nv_mode_t mode, mode_n;
  logic is_store, is_recall, store_edge, recall_edge, pwr_rise;
  logic load, expire, sgo_n, rgo_n;
  logic [CW-1:0] len_m1;

  nvs_cmd_decode u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n), .busy(busy),
    .is_store(is_store), .is_recall(is_recall),
    .sram_rd(sram_rd), .sram_wr(sram_wr)
  );

  nvs_edge_arm u_edge (
    .clk(clk), .rst_n(rst_n), .is_store(is_store), .is_recall(is_recall),
    .supply_ok(supply_ok), .store_edge(store_edge),
    .recall_edge(recall_edge), .pwr_rise(pwr_rise)
  );

  nvs_cycle_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .len_m1(len_m1), .expire(expire)
  );

  always_comb begin
    mode_n = mode;
    load   = 1'b0;
    len_m1 = '0;
    sgo_n  = 1'b0;
    rgo_n  = 1'b0;
    if (pwr_rise) begin
      mode_n = NV_RECALL;
      load   = 1'b1;
      len_m1 = RS_M1;
      rgo_n  = 1'b1;
    end else begin
      unique case (mode)
        NV_STORE: begin
          if (!supply_ok || expire) mode_n = NV_IDLE;
        end
        NV_RECALL: begin
          if (expire) mode_n = NV_IDLE;
        end
        default: begin
          if (store_edge && supply_ok) begin
            mode_n = NV_STORE;
            load   = 1'b1;
            len_m1 = ST_M1;
            sgo_n  = 1'b1;
          end else if (recall_edge) begin
            mode_n = NV_RECALL;
            load   = 1'b1;
            len_m1 = RC_M1;
            rgo_n  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= NV_IDLE;
      store_go  <= 1'b0;
      recall_go <= 1'b0;
    end else begin
      mode      <= mode_n;
      store_go  <= sgo_n;
      recall_go <= rgo_n;
    end
  end

  assign busy = (mode != NV_IDLE);
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       store_go,
  input logic       recall_go,
  input logic       busy,
  input logic       sram_rd,
  input logic       sram_wr,
  input logic [1:0] mode
);
  a_r1_store_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> busy);
  a_r1_store_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |=> !store_go);
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_go && recall_go));
  a_r4_no_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sram_rd && !sram_wr));
  a_r4_store_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> !$past(busy));
  a_r5_store_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> $past(supply_ok));
  a_r6_abort_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !supply_ok) |=> !busy);
  a_r7_power_recall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok) |=> recall_go);
  a_r8_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_rd && sram_wr));
endmodule

bind nvs_ctrl nvs_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .store_go(store_go),
  .recall_go(recall_go), .busy(busy), .sram_rd(sram_rd), .sram_wr(sram_wr),
  .mode(mode)
);

// File: tb/nvs_ctrl_bench.sv
module nvs_ctrl_bench;
  localparam int ST = 20, RC = 6, RS = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1, vk = 1'b1;
  logic store_go, recall_go, busy, sram_rd, sram_wr;

  int checks = 0, errors = 0, sgo_cnt = 0, rgo_cnt = 0;
  bit done = 0;

  // Behavioural reference state
  int m_mode = 0, m_rem = 0;
  bit m_pst = 0, m_prc = 0, m_vq = 0, m_armed = 0, m_sgo = 0, m_rgo = 0;

  always #2.5 clk = ~clk;

  nvs_ctrl #(.STORE_CLKS(ST), .RECALL_CLKS(RC), .RESTORE_CLKS(RS)) u_nvs_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .nv_n(nv_n), .supply_ok(vk), .store_go(store_go), .recall_go(recall_go),
    .busy(busy), .sram_rd(sram_rd), .sram_wr(sram_wr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_pst = 0; m_prc = 0; m_vq = 0;
      m_armed = 0; m_sgo = 0; m_rgo = 0;
    end else begin
      bit st, rc;
      st = !nv_n && !ce_n && !we_n && oe_n;
      rc = !nv_n && !ce_n && !oe_n && we_n;
      m_sgo = 0; m_rgo = 0;
      if (vk && !m_vq) begin m_mode = 2; m_rem = RS; m_rgo = 1; end
      else if (m_mode == 1 && !vk) m_mode = 0;
      else if (m_mode != 0) begin
        if (m_rem == 1) m_mode = 0; else m_rem--;
      end
      else if (m_armed && st && !m_pst && vk) begin m_mode = 1; m_rem = ST; m_sgo = 1; end
      else if (m_armed && rc && !m_prc) begin m_mode = 2; m_rem = RC; m_rgo = 1; end
      m_pst = st; m_prc = rc; m_vq = vk; m_armed = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    bit eb, er, ew;
    @(negedge clk);
    eb = (m_mode != 0);
    er = !eb && !ce_n && !oe_n && we_n && nv_n;
    ew = !eb && !ce_n && !we_n && nv_n;
    chk(busy == eb, "R1/R2 busy", busy, eb);
    chk(store_go == m_sgo, "R1 store_go", store_go, m_sgo);
    chk(recall_go == m_rgo, "R2/R7 recall_go", recall_go, m_rgo);
    chk(sram_rd == er, "R8 sram_rd", sram_rd, er);
    chk(sram_wr == ew, "R8 sram_wr", sram_wr, ew);
    if (store_go) sgo_cnt++;
    if (recall_go) rgo_cnt++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set(input bit c, input bit o, input bit w, input bit n, input bit v);
    ce_n = c; oe_n = o; we_n = w; nv_n = n; vk = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int s0, r0, bcnt;
    // R9: reset with supply up and a STORE level already applied
    set(0, 1, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk(!busy && !store_go && !recall_go, "R9 reset outputs", busy, 0);
    rst_n = 1'b1;
    run(RS + 8);
    chk(rgo_cnt == 1, "R7 power-up recall", rgo_cnt, 1);
    chk(sgo_cnt == 0, "R3 level at reset ignored", sgo_cnt, 0);

    // R8: plain read then write
    set(1, 1, 1, 1, 1); run(2);
    set(0, 0, 1, 1, 1); tick();
    chk(sram_rd == 1, "R8 read gate", sram_rd, 1);
    set(0, 1, 0, 1, 1); tick();
    chk(sram_wr == 1, "R8 write gate", sram_wr, 1);

    // R1/R4: STORE, then read and recall edges while busy
    set(1, 1, 1, 1, 1); run(2);
    s0 = sgo_cnt; r0 = rgo_cnt;
    set(0, 1, 0, 0, 1); tick();
    chk(store_go && busy, "R1 store start", store_go, 1);
    set(0, 0, 1, 1, 1); tick();
    chk(sram_rd == 0, "R4 read blocked while busy", sram_rd, 0);
    set(0, 0, 1, 0, 1);
    bcnt = 2;
    while (busy && bcnt < 100) begin tick(); if (busy) bcnt++; end
    chk(bcnt == ST, "R1 store length", bcnt, ST);
    run(5);
    chk(rgo_cnt == r0, "R4 edge during busy discarded", rgo_cnt, r0);

    // R3: STORE held past its end
    set(1, 1, 1, 1, 1); run(2);
    s0 = sgo_cnt;
    set(0, 1, 0, 0, 1); run(ST + 10);
    chk(sgo_cnt == s0 + 1, "R3 held store single", sgo_cnt, s0 + 1);

    // R2/R8: RECALL with nv_n last, read waiting at the end
    set(0, 0, 1, 1, 1); run(2);
    set(0, 0, 1, 0, 1); tick();
    chk(recall_go && busy, "R2 recall start", recall_go, 1);
    bcnt = 1;
    set(0, 0, 1, 1, 1);
    while (busy && bcnt < 100) begin tick(); if (busy) bcnt++; end
    chk(bcnt == RC, "R2 recall length", bcnt, RC);
    chk(sram_rd == 1, "R8 read as busy falls", sram_rd, 1);

    // R5: STORE edge with supply low
    set(1, 1, 1, 1, 0); run(2);
    s0 = sgo_cnt;
    set(0, 1, 0, 0, 0); run(4);
    chk(sgo_cnt == s0 && !busy, "R5 store blocked", sgo_cnt, s0);

    // R7: supply rises at the same edge as a STORE edge
    set(1, 1, 1, 1, 0); run(2);
    s0 = sgo_cnt;
    set(0, 1, 0, 0, 1); tick();
    chk(recall_go == 1 && store_go == 0, "R7 auto recall wins", recall_go, 1);
    run(RS + 6);
    chk(sgo_cnt == s0, "R7 store command discarded", sgo_cnt, s0);

    // R6: supply drops during STORE
    set(1, 1, 1, 1, 1); run(2);
    set(0, 1, 0, 0, 1); run(3);
    chk(busy == 1, "R6 store running", busy, 1);
    vk = 1'b0; tick();
    chk(busy == 0, "R6 store aborted", busy, 0);
    run(3);
    finish_run();
  end
endmodule